// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block drives one pulse-width-modulated output from a private 16-bit time base. Software sets a period and a pulse width through a small register bus. Both values land in staging registers first. The engine copies them into its working registers only when a period ends, so a write made in the middle of a period never produces a cut-short or stretched cycle.

The counter clock comes from a local selector. One setting divides the system clock by two. The other settings count pulses of a shared prescaled-clock enable and divide them by a power of two. A polarity bit picks whether the active level is high or low. A width of zero keeps the output inactive with no pulse at all. A width at or above the period keeps the output active without ever dropping. Each period end raises a sticky status flag, and that flag can also be routed to an interrupt request.

Top module: `pwm_gen`

## Requirements
- R1: After reset, `pwm_out` is 0, `irq` is 0, and the control register and counter both read 0.
- R2: The register map uses `bus_addr` 0 for control, 1 for staged period, 2 for staged width and 3 for the counter (read-only). Control bits are: bit 0 enable, bit 1 invert (1 = active-low), bits 4:2 clock select, bit 5 interrupt enable, bit 15 period flag. Writing 1 to bit 15 clears the flag. Unused control bits read 0. The staged period and width read back as written.
- R3: With clock select 0, the counter advances once every two system clock cycles.
- R4: With period P ≥ 1 and 0 < W < P, the counter steps through 1..P in each period. The output is active for W counts and inactive for P−W counts.
- R5: Writes to the staged period or width during a period leave that period unchanged. The new values apply from the next period boundary.
- R6: With width 0, the output stays at the inactive level for the whole period.
- R7: With width ≥ period (width nonzero), the output stays at the active level with no inactive gap.
- R8: With the invert bit set, the output is low while active and high while inactive.
- R9: Every period boundary sets the flag. `irq` equals the flag ANDed with the interrupt-enable bit. Writing 1 to control bit 15 clears the flag.
- R10: While enable is 0, the counter reads 0 and the output sits at the inactive level chosen by the invert bit.
- R11: With clock select k in 1..7, the counter advances once per 2^(k−1) pulses of `pclk_en`.
- R12: With clock select 0, period 2 and width 1, the output pulse lasts exactly two system clock cycles, which is the shortest pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_en | input | 1 | One-cycle pulses from the shared prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Modulated output, registered |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a staging write that lands inside a running period. The bench waits for a rising edge of the output, which marks a period boundary. It then issues width and period writes on the next two cycles while the pulse is still high. It checks that the rest of that period keeps the old timing and that the following period follows the new values. The 100% and 0% cases are held for many periods, so that any one-cycle glitch at a boundary shows up in a per-cycle sample.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_PERIOD = 2'd1,
        ADDR_WIDTH  = 2'd2,
        ADDR_COUNT  = 2'd3
    } reg_addr_e;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_INV_BIT = 1;
    localparam int CTL_SEL_LSB = 2;
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             period_done_i,
    output logic             enable_o,
    output logic             invert_o,
    output logic [SEL_W-1:0] clk_sel_o,
    output logic [CNT_W-1:0] per_nxt_o,
    output logic [CNT_W-1:0] wid_nxt_o,
    output logic             irq_o
);
    localparam int IRQ_BIT  = CTL_SEL_LSB + SEL_W;
    localparam int FLAG_BIT = CNT_W - 1;

    typedef struct packed {
        logic             enable;
        logic             invert;
        logic [SEL_W-1:0] sel;
        logic             irq_en;
        logic             flag;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
    } regs_t;

    regs_t r_d, r_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i[FLAG_BIT-1:IRQ_BIT+1];

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            case (reg_addr_e'(addr_i))
                ADDR_CTRL: begin
                    r_d.enable = wdata_i[CTL_EN_BIT];
                    r_d.invert = wdata_i[CTL_INV_BIT];
                    r_d.sel    = wdata_i[CTL_SEL_LSB +: SEL_W];
                    r_d.irq_en = wdata_i[IRQ_BIT];
                    if (wdata_i[FLAG_BIT]) r_d.flag = 1'b0;
                end
                ADDR_PERIOD: r_d.per = wdata_i;
                ADDR_WIDTH:  r_d.wid = wdata_i;
                default: ;
            endcase
        end
        if (period_done_i) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (reg_addr_e'(addr_i))
            ADDR_CTRL: begin
                rdata_o[CTL_EN_BIT]              = r_q.enable;
                rdata_o[CTL_INV_BIT]             = r_q.invert;
                rdata_o[CTL_SEL_LSB +: SEL_W]    = r_q.sel;
                rdata_o[IRQ_BIT]                 = r_q.irq_en;
                rdata_o[FLAG_BIT]                = r_q.flag;
            end
            ADDR_PERIOD: rdata_o = r_q.per;
            ADDR_WIDTH:  rdata_o = r_q.wid;
            default:     rdata_o = cnt_i;
        endcase
    end

    assign enable_o  = r_q.enable;
    assign invert_o  = r_q.invert;
    assign clk_sel_o = r_q.sel;
    assign per_nxt_o = r_q.per;
    assign wid_nxt_o = r_q.wid;
    assign irq_o     = r_q.flag & r_q.irq_en;

    // A boundary seen by the engine must leave the flag set on the next cycle.
    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        period_done_i |=> r_q.flag);

    // A clear with no boundary in the same cycle leaves the flag low.
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd0 && wdata_i[FLAG_BIT] && !period_done_i) |=> !r_q.flag);
endmodule

// File: rtl/pwm_clksel.sv
`timescale 1ns/1ps
module pwm_clksel #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             pclk_en_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << SEL_W) - 2;

    typedef struct packed {
        logic             half;
        logic [DIV_W-1:0] div;
    } sel_t;

    sel_t s_d, s_q;
    logic [DIV_W:0]   mask_wide;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask_wide = ((DIV_W+1)'(1) << (sel_i - SEL_W'(1))) - (DIV_W+1)'(1);
        mask      = mask_wide[DIV_W-1:0];
        if (sel_i == '0) tick_o = s_q.half;
        else             tick_o = pclk_en_i && ((s_q.div & mask) == mask);

        s_d = s_q;
        if (!enable_i) begin
            s_d = '0;
        end else begin
            s_d.half = ~s_q.half;
            if (pclk_en_i) s_d.div = s_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Divide-by-two setting never ticks on two adjacent cycles.
    assert_sel0_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && sel_i == '0 && tick_o) |=> (!tick_o || sel_i != '0));

    // Nothing ticks while the block is off.
    assert_idle_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (s_q.half == 1'b0 && s_q.div == '0));
endmodule

// File: rtl/pwm_engine.sv
`timescale 1ns/1ps
module pwm_engine #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             invert_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] per_nxt_i,
    input  logic [CNT_W-1:0] wid_nxt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pwm_o,
    output logic             period_done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per_cur;
        logic [CNT_W-1:0] wid_cur;
        logic             act;
        logic             out;
    } eng_t;

    eng_t s_d, s_q;
    logic boundary;
    logic nxt_zero;
    logic cur_full;

    always_comb begin
        boundary = (s_q.cnt == '0) || (s_q.cnt >= s_q.per_cur);
        nxt_zero = (wid_nxt_i == '0);
        cur_full = (s_q.wid_cur >= s_q.per_cur);
        period_done_o = 1'b0;
        s_d = s_q;

        if (!enable_i) begin
            s_d.cnt = '0;
            s_d.act = 1'b0;
        end else if (tick_i) begin
            if (boundary) begin
                period_done_o = 1'b1;
                s_d.cnt       = CNT_W'(1);
                s_d.per_cur   = per_nxt_i;
                s_d.wid_cur   = wid_nxt_i;
                s_d.act       = !nxt_zero;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
                if (!cur_full && s_q.cnt == s_q.wid_cur) s_d.act = 1'b0;
            end
        end
        s_d.out = s_d.act ^ invert_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign pwm_o = s_q.out;

    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && s_q.per_cur != '0) |-> (s_q.cnt <= s_q.per_cur));

    assert_stage_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_i && tick_i && boundary) |=> ($stable(s_q.per_cur) && $stable(s_q.wid_cur)));

    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && tick_i && boundary && wid_nxt_i == '0) |=> !s_q.act);

    assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && s_q.cnt != '0 && s_q.wid_cur != '0 && s_q.wid_cur >= s_q.per_cur) |-> s_q.act);

    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (s_q.cnt == '0 && s_q.out == $past(invert_i)));
endmodule

// File: rtl/pwm_gen.sv
`timescale 1ns/1ps
module pwm_gen #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk_en,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             pwm_out,
    output logic             irq
);
    logic             enable;
    logic             invert;
    logic [SEL_W-1:0] clk_sel;
    logic [CNT_W-1:0] per_nxt;
    logic [CNT_W-1:0] wid_nxt;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             period_done;

    pwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (bus_wr),
        .addr_i        (bus_addr),
        .wdata_i       (bus_wdata),
        .rdata_o       (bus_rdata),
        .cnt_i         (cnt),
        .period_done_i (period_done),
        .enable_o      (enable),
        .invert_o      (invert),
        .clk_sel_o     (clk_sel),
        .per_nxt_o     (per_nxt),
        .wid_nxt_o     (wid_nxt),
        .irq_o         (irq)
    );

    pwm_clksel #(.SEL_W(SEL_W)) u_clksel (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .sel_i     (clk_sel),
        .pclk_en_i (pclk_en),
        .tick_o    (tick)
    );

    pwm_engine #(.CNT_W(CNT_W)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable),
        .invert_i      (invert),
        .tick_i        (tick),
        .per_nxt_i     (per_nxt),
        .wid_nxt_i     (wid_nxt),
        .cnt_o         (cnt),
        .pwm_o         (pwm_out),
        .period_done_o (period_done)
    );
endmodule

// File: tb/pwm_gen_tb.sv
`timescale 1ns/1ps
module pwm_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        pwm_out;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    int pc_cnt  = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        pc_cnt  <= (pc_cnt == 2) ? 0 : pc_cnt + 1;
        pclk_en <= (pc_cnt == 2);
    end

    pwm_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .irq(irq)
    );

    function automatic logic [15:0] ctl(input logic en, input logic inv,
                                        input logic [2:0] sel, input logic ie);
        return {10'd0, ie, sel, inv, en};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic setup(input int per, input int wid, input logic [15:0] c);
        wr(2'd0, 16'd0);
        wr(2'd1, 16'(per));
        wr(2'd2, 16'(wid));
        wr(2'd0, c);
    endtask

    task automatic wait_edge(input logic lvl);
        for (int i = 0; i < 2000 && pwm_out == lvl; i++) @(negedge clk);
        for (int i = 0; i < 2000 && pwm_out != lvl; i++) @(negedge clk);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (pwm_out == lvl && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input logic lvl, output int act_n, output int inact_n);
        wait_edge(lvl);
        run_len(lvl, act_n);
        run_len(!lvl, inact_n);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 out", int'(pwm_out), 0);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        rd(2'd0, d); check(d == 16'd0, "R1 ctrl", d, 0);
        rd(2'd3, d); check(d == 16'd0, "R1 count", d, 0);
    endtask

    task automatic t_regmap;
        logic [15:0] d;
        wr(2'd1, 16'h1234); rd(2'd1, d); check(d == 16'h1234, "R2 period", d, 16'h1234);
        wr(2'd2, 16'hA5C3); rd(2'd2, d); check(d == 16'hA5C3, "R2 width", d, 16'hA5C3);
        wr(2'd0, 16'h7FFE); rd(2'd0, d); check(d == 16'h003E, "R2 ctrl", d, 16'h003E);
        wr(2'd0, 16'h0000); rd(2'd0, d); check(d == 16'h0000, "R2 ctrl clr", d, 0);
    endtask

    task automatic t_rate;
        logic [15:0] a, b;
        setup(1000, 500, ctl(1, 0, 3'd0, 0));
        repeat (20) @(negedge clk);
        rd(2'd3, a);
        repeat (10) @(negedge clk);
        rd(2'd3, b);
        check(b - a == 16'd5, "R3 count step", int'(b - a), 5);
    endtask

    task automatic t_basic;
        int h, l, mn, mx;
        logic [15:0] d;
        setup(5, 2, ctl(1, 0, 3'd0, 0));
        measure(1'b1, h, l);
        check(h == 4, "R4 high P5W2", h, 4);
        check(l == 6, "R4 low P5W2", l, 6);
        mn = 99; mx = 0;
        for (int i = 0; i < 30; i++) begin
            rd(2'd3, d);
            if (int'(d) < mn) mn = int'(d);
            if (int'(d) > mx) mx = int'(d);
            @(negedge clk);
        end
        check(mn == 1, "R4 count min", mn, 1);
        check(mx == 5, "R4 count max", mx, 5);
        setup(7, 3, ctl(1, 0, 3'd0, 0));
        measure(1'b1, h, l);
        check(h == 6, "R4 high P7W3", h, 6);
        check(l == 8, "R4 low P7W3", l, 8);
    endtask

    task automatic t_stage;
        int h, l;
        setup(8, 2, ctl(1, 0, 3'd0, 0));
        wait_edge(1'b1);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'd6;
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 16'd10;
        @(negedge clk);
        bus_wr = 1'b0;
        run_len(1'b1, h);
        run_len(1'b0, l);
        check(h + 2 == 4, "R5 old high kept", h + 2, 4);
        check(l == 12, "R5 old low kept", l, 12);
        measure(1'b1, h, l);
        check(h == 12, "R5 new high", h, 12);
        check(l == 8, "R5 new low", l, 8);
    endtask

    task automatic t_zero;
        int hits;
        setup(5, 0, ctl(1, 0, 3'd0, 0));
        hits = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pwm_out) hits++;
        end
        check(hits == 0, "R6 zero duty active cycles", hits, 0);
    endtask

    task automatic t_full;
        int miss;
        setup(5, 5, ctl(1, 0, 3'd0, 0));
        repeat (4) @(negedge clk);
        miss = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!pwm_out) miss++;
        end
        check(miss == 0, "R7 W=P inactive cycles", miss, 0);
        setup(5, 9, ctl(1, 0, 3'd0, 0));
        repeat (4) @(negedge clk);
        miss = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!pwm_out) miss++;
        end
        check(miss == 0, "R7 W>P inactive cycles", miss, 0);
    endtask

    task automatic t_invert;
        int h, l;
        setup(5, 2, ctl(1, 1, 3'd0, 0));
        measure(1'b0, l, h);
        check(l == 4, "R8 active-low span", l, 4);
        check(h == 6, "R8 inactive-high span", h, 6);
    endtask

    task automatic t_flag;
        logic [15:0] d;
        setup(3, 1, ctl(1, 0, 3'd0, 1));
        repeat (20) @(negedge clk);
        rd(2'd0, d);
        check(d[15] == 1'b1, "R9 flag set", int'(d[15]), 1);
        check(irq == 1'b1, "R9 irq with enable", int'(irq), 1);
        wr(2'd0, 16'h8000);
        repeat (3) @(negedge clk);
        rd(2'd0, d);
        check(d[15] == 1'b0, "R9 flag cleared", int'(d[15]), 0);
        check(irq == 1'b0, "R9 irq after clear", int'(irq), 0);
        wr(2'd0, ctl(1, 0, 3'd0, 0));
        repeat (20) @(negedge clk);
        rd(2'd0, d);
        check(d[15] == 1'b1, "R9 flag without ie", int'(d[15]), 1);
        check(irq == 1'b0, "R9 irq masked", int'(irq), 0);
    endtask

    task automatic t_disable;
        logic [15:0] d;
        int bad;
        setup(5, 2, ctl(1, 1, 3'd0, 0));
        repeat (13) @(negedge clk);
        wr(2'd0, ctl(0, 1, 3'd0, 0));
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out != 1'b1) bad++;
        end
        check(bad == 0, "R10 inverted idle level", bad, 0);
        rd(2'd3, d); check(d == 16'd0, "R10 count held", d, 0);
        wr(2'd0, ctl(0, 0, 3'd0, 0));
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b0, "R10 plain idle level", int'(pwm_out), 0);
    endtask

    task automatic t_presc;
        int h, l;
        setup(4, 1, ctl(1, 0, 3'd3, 0));
        measure(1'b1, h, l);
        check(h == 12, "R11 sel3 high", h, 12);
        check(l == 36, "R11 sel3 low", l, 36);
        setup(4, 2, ctl(1, 0, 3'd1, 0));
        measure(1'b1, h, l);
        check(h == 6, "R11 sel1 high", h, 6);
        check(l == 6, "R11 sel1 low", l, 6);
    endtask

    task automatic t_min;
        int h, l;
        setup(2, 1, ctl(1, 0, 3'd0, 0));
        measure(1'b1, h, l);
        check(h == 2, "R12 min pulse", h, 2);
        check(l == 2, "R12 min gap", l, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_rate;
        t_basic;
        t_stage;
        t_zero;
        t_full;
        t_invert;
        t_flag;
        t_disable;
        t_presc;
        t_min;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule